// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter

A four-bit synchronous counter that runs either through the full binary range (0 to 15) or through a single BCD digit (0 to 9), in either direction, on the rising edge of one clock. A run-time select picks the modulus and another picks the direction. An active-high preset input overrides everything: while it is high the count output follows the four parallel jam inputs at once, with no clock needed.

Counting is gated by an active-low carry input, which acts as a clock enable. The active-low carry output falls when the counter sits at its terminal value for the present direction and its carry input is low. It is a purely combinational function of the carry input, so several counters on a shared clock can be chained with each carry output feeding the next carry input. This forms a multi-digit decimal or a wide binary counter with look-ahead carry.

Top module: `updn_digit_counter`

## Requirements
- R1: While `preset_en` is 1, `count` equals `jam` without any clock edge. A clock edge while `preset_en` is 1 leaves `count` at `jam` and never advances it.
- R2: With `preset_en` at 1 and `jam` = 0, `count` reads 0 and stays 0 across clock edges.
- R3: With `preset_en` at 0 and `carry_in_n` at 0, each rising clock edge moves `count` by exactly one step.
- R4: With `carry_in_n` at 1, clock edges leave `count` unchanged and `carry_out_n` stays 1.
- R5: `bin_mode` = 1 selects modulus 16 (values 0 to 15). `bin_mode` = 0 selects modulus 10 (values 0 to 9).
- R6: `count_up` = 1 increments the count and `count_up` = 0 decrements it.
- R7: `carry_out_n` is 0 exactly when `carry_in_n` is 0 and the count is terminal. Terminal means 15 (binary, up), 9 (decade, up) or 0 (down). Otherwise it is 1.
- R8: In binary mode, up from 15 gives 0 and down from 0 gives 15. In decade mode, up from 9 gives 0 and down from 0 gives 9.
- R9: In decade mode, a count of 10 to 15 goes to 0 when counting up and to one less when counting down. `carry_out_n` stays 1 on these values.
- R10: After `preset_en` falls, the first enabled clock edge advances from the jammed value by one step.
- R11: Three counters on a shared clock, each `carry_out_n` driving the next `carry_in_n`, count as a three-digit decimal or a twelve-bit binary counter in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| preset_en | input | 1 | Asynchronous parallel load, active high |
| jam | input | 4 | Parallel load value |
| carry_in_n | input | 1 | Count enable, active low |
| bin_mode | input | 1 | 1 = binary modulus 16, 0 = decade modulus 10 |
| count_up | input | 1 | 1 = up, 0 = down |
| count | output | 4 | Current count |
| carry_out_n | output | 1 | Terminal-count carry, active low |

## Verification
A vector table starts the counter from chosen values in all four mode and direction pairs. It separates ordinary steps from wraps at both ends of each modulus, and from the illegal decade values 10 to 15. For each start value it checks both the step and the carry level, so a wrong terminal decode cannot hide behind a correct step. Directed cases hold the clock-enable high at a terminal value, clock while preset is held, and change the jam inputs with no clock to show the load is asynchronous. A three-stage chain is compared cycle by cycle against a plain integer counter across the decimal wrap 999 to 000, a downward borrow through zero, and a binary roll-over at 4095.

// File: rtl/updn_digit_counter.sv
module updn_digit_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         preset_en,
  input  logic [W-1:0] jam,
  input  logic         carry_in_n,
  input  logic         bin_mode,
  input  logic         count_up,
  output logic [W-1:0] count,
  output logic         carry_out_n
);
  localparam logic [W-1:0] BIN_TOP = {W{1'b1}};
  localparam logic [W-1:0] DEC_TOP = W'(9);

  logic [W-1:0] cnt_q, cnt_nxt, top;
  logic         terminal;

  assign top   = bin_mode ? BIN_TOP : DEC_TOP;
  assign count = preset_en ? jam : cnt_q;

  always_comb begin
    if (count_up)
      cnt_nxt = (!bin_mode && cnt_q >= DEC_TOP) ? '0 : cnt_q + 1'b1;
    else
      cnt_nxt = (cnt_q == '0) ? top : cnt_q - 1'b1;
  end

  assign terminal    = count_up ? (count == top) : (count == '0);
  assign carry_out_n = ~(~carry_in_n & terminal);

  always_ff @(posedge clk or posedge preset_en) begin
    if (preset_en)
      cnt_q <= jam;
    else if (!carry_in_n)
      cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/updn_digit_counter_chk.sv
module updn_digit_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         preset_en,
  input logic [W-1:0] jam,
  input logic         carry_in_n,
  input logic         bin_mode,
  input logic         count_up,
  input logic [W-1:0] count,
  input logic         carry_out_n
);
  assert_bin_up_step_R3: assert property (@(posedge clk) disable iff (preset_en)
    (!carry_in_n && count_up && bin_mode) |=> count == W'($past(count) + 1'b1));

  assert_hold_when_disabled_R4: assert property (@(posedge clk) disable iff (preset_en)
    carry_in_n |=> $stable(count));

  assert_carry_idle_R7: assert property (@(posedge clk) disable iff (preset_en)
    carry_in_n |-> carry_out_n);

  assert_dec_stays_legal_R5: assert property (@(posedge clk) disable iff (preset_en)
    (!carry_in_n && !bin_mode && count <= W'(9)) |=> count <= W'(9));

  assert_dec_down_wrap_R8: assert property (@(posedge clk) disable iff (preset_en)
    (!carry_in_n && !bin_mode && !count_up && count == '0) |=> count == W'(9));

  assert_illegal_no_carry_R9: assert property (@(posedge clk) disable iff (preset_en)
    (!bin_mode && count > W'(9)) |-> carry_out_n);
endmodule

bind updn_digit_counter updn_digit_counter_chk #(.W(W)) u_chk (.*);

// File: tb/test_updn_digit_counter.sv
module test_updn_digit_counter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;

  logic       pe = 1'b1, cin_n = 1'b1, bin = 1'b1, up = 1'b1;
  logic [3:0] jam = 4'd0, q;
  logic       co_n;

  updn_digit_counter i_updn_digit_counter (
    .clk(clk), .preset_en(pe), .jam(jam), .carry_in_n(cin_n),
    .bin_mode(bin), .count_up(up), .count(q), .carry_out_n(co_n));

  logic        c_pe = 1'b1, c_en_n = 1'b1, c_bin = 1'b0, c_up = 1'b1;
  logic [11:0] c_jam = '0;
  logic [3:0]  d0, d1, d2;
  logic        k0, k1, k2;

  updn_digit_counter i_updn_digit_counter_c0 (.clk(clk), .preset_en(c_pe), .jam(c_jam[3:0]),
    .carry_in_n(c_en_n), .bin_mode(c_bin), .count_up(c_up), .count(d0), .carry_out_n(k0));
  updn_digit_counter i_updn_digit_counter_c1 (.clk(clk), .preset_en(c_pe), .jam(c_jam[7:4]),
    .carry_in_n(k0), .bin_mode(c_bin), .count_up(c_up), .count(d1), .carry_out_n(k1));
  updn_digit_counter i_updn_digit_counter_c2 (.clk(clk), .preset_en(c_pe), .jam(c_jam[11:8]),
    .carry_in_n(k1), .bin_mode(c_bin), .count_up(c_up), .count(d2), .carry_out_n(k2));

  // {start, bin, up, expected next, expected carry_out_n}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {4'd5,  1'b1, 1'b1, 4'd6,  1'b1},
    {4'd15, 1'b1, 1'b1, 4'd0,  1'b0},
    {4'd0,  1'b1, 1'b1, 4'd1,  1'b1},
    {4'd0,  1'b1, 1'b0, 4'd15, 1'b0},
    {4'd7,  1'b1, 1'b0, 4'd6,  1'b1},
    {4'd15, 1'b1, 1'b0, 4'd14, 1'b1},
    {4'd8,  1'b0, 1'b1, 4'd9,  1'b1},
    {4'd9,  1'b0, 1'b1, 4'd0,  1'b0},
    {4'd12, 1'b0, 1'b1, 4'd0,  1'b1},
    {4'd15, 1'b0, 1'b1, 4'd0,  1'b1},
    {4'd0,  1'b0, 1'b0, 4'd9,  1'b0},
    {4'd9,  1'b0, 1'b0, 4'd8,  1'b1},
    {4'd11, 1'b0, 1'b0, 4'd10, 1'b1},
    {4'd10, 1'b0, 1'b0, 4'd9,  1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic int chain_val(input logic b);
    if (b) return {d2, d1, d0};
    return int'(d2) * 100 + int'(d1) * 10 + int'(d0);
  endfunction

  task automatic run_chain(input logic b, input logic u, input int start, input int steps);
    int modv = b ? 4096 : 1000;
    int v = start;
    tick();
    c_bin = b; c_up = u; c_pe = 1'b1; c_en_n = 1'b1;
    c_jam = b ? 12'(start) : {4'(start / 100), 4'((start / 10) % 10), 4'(start % 10)};
    tick();
    c_pe = 1'b0; c_en_n = 1'b0;
    #1;
    check("R11 chain preset", chain_val(b), v);
    for (int i = 0; i < steps; i++) begin
      int term = u ? modv - 1 : 0;
      check("R11 chain carry", int'(k2), (v == term) ? 0 : 1);
      tick();
      v = u ? (v + 1) % modv : (v + modv - 1) % modv;
      check("R11 chain value", chain_val(b), v);
    end
    c_en_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2;
    check("R2 zero jam", int'(q), 0);
    check("R4 idle carry", int'(co_n), 1);
    tick();
    check("R2 zero held over edge", int'(q), 0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] e = VEC[i];
      pe = 1'b1; jam = e[10:7]; cin_n = 1'b1; bin = e[6]; up = e[5];
      #1;
      check("R1 jam load", int'(q), int'(e[10:7]));
      tick();
      pe = 1'b0; cin_n = 1'b0;
      #1;
      check("R7 R9 carry decode", int'(co_n), int'(e[0]));
      tick();
      check("R3 R5 R6 R8 R9 step", int'(q), int'(e[4:1]));
      cin_n = 1'b1;
    end

    pe = 1'b1; jam = 4'd15; bin = 1'b1; up = 1'b1; cin_n = 1'b1;
    tick();
    pe = 1'b0;
    repeat (3) tick();
    check("R4 hold count", int'(q), 15);
    check("R4 carry high while disabled", int'(co_n), 1);

    cin_n = 1'b0; jam = 4'd6; pe = 1'b1; bin = 1'b0;
    tick();
    check("R1 no advance under preset", int'(q), 6);
    jam = 4'd3;
    #1;
    check("R1 async follow", int'(q), 3);
    tick();
    pe = 1'b0;
    #1;
    check("R10 value after release", int'(q), 3);
    tick();
    check("R10 first step after release", int'(q), 4);
    cin_n = 1'b1;

    run_chain(1'b0, 1'b1, 995, 12);
    run_chain(1'b0, 1'b0, 5, 20);
    run_chain(1'b0, 1'b0, 101, 4);
    run_chain(1'b1, 1'b1, 4090, 12);
    run_chain(1'b1, 1'b0, 258, 6);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule